// File: doc/BRIEF.md
# Receive-side scaling queue classifier

This block steers each received packet to one of two receive queues and names a target CPU for it. The packet arrives as a single-cycle pulse carrying an already computed 32-bit flow hash, a 4-bit code naming the hash inputs that were used, and a flag that says whether the header could be parsed for hashing. The low seven hash bits select one of 128 entries in a redirection table. Each entry holds a queue-select bit and a 5-bit CPU number.

Classification is switched on by two configuration inputs together: a checksum-off control bit and a 2-bit multi-queue mode field. When either condition fails, or the packet cannot be parsed, the packet goes to queue 0 and the tag, type, CPU and status outputs are all zero. Software fills the table through a simple write port. It may rewrite the table at any time, and the usual practice is to do so while classification is off.

Top module: `rxq_steer`

## Requirements
- R1: Classification is active only when `cfg_csum_off` is 1 and `cfg_mq_mode` is not 2'b00. All other combinations count as inactive.
- R2: A lookup made while classification is inactive gives `out_queue`=0 and zero `out_tag`, `out_htype`, `out_cpu` and `out_status`.
- R3: A lookup made while classification is active with `in_decodable`=0 gives queue 0 and zero tag, type, CPU and status.
- R4: A classified lookup reads the table entry at index `in_hash[6:0]`. It reports the entry's bit 5 on `out_queue` and bits 4:0 on `out_cpu`.
- R5: A classified lookup passes all 32 bits of `in_hash` unchanged to `out_tag`.
- R6: A classified lookup passes `in_htype` unchanged to `out_htype`.
- R7: `out_valid` is `in_valid` delayed by exactly one clock, and the results belong to that input. There is no backpressure.
- R8: When `tbl_wr_en` is 1, `tbl_wr_data` is written to the entry at `tbl_wr_addr` (bit 5 is the queue, bits 4:0 are the CPU). Reset clears every entry to zero.
- R9: A lookup and a write to the same entry in the same cycle return the entry's previous contents. Later lookups see the new value.
- R10: While `out_valid` is 0, all result outputs are zero.
- R11: `out_status` is `{out_htype, out_queue, out_cpu}`: type in bits 9:6, queue in bit 5, CPU in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_csum_off | input | 1 | Checksum-off control; must be 1 for classification |
| cfg_mq_mode | input | 2 | Multi-queue mode; nonzero enables classification |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 7 | Table entry to write |
| tbl_wr_data | input | 6 | {queue bit, CPU[4:0]} |
| in_valid | input | 1 | Packet lookup pulse |
| in_hash | input | 32 | Flow hash of the packet |
| in_htype | input | 4 | Code naming the hash inputs used |
| in_decodable | input | 1 | 1 when the packet could be parsed for hashing |
| out_valid | output | 1 | Result pulse, one clock after `in_valid` |
| out_queue | output | 1 | Selected receive queue |
| out_cpu | output | 5 | Target CPU number |
| out_tag | output | 32 | Descriptor tag |
| out_htype | output | 4 | Hash type for the descriptor |
| out_status | output | 10 | Packed descriptor status field |

## Verification
The hardest case to reach from the ports is a write and a lookup that land on the same table entry in the same clock. In that cycle the old contents must come out, and the new contents must appear from the next lookup on. The stimulus reaches this by deriving the write address from the hash it presents in that same cycle, with a fresh value that differs from the stored one. It then looks up the same index again to confirm the update. Enable combinations are swept exhaustively. The whole table is also rewritten while classification is off, so that a change in the table cannot leak into the zeroed results.

// File: rtl/rxq_steer_pkg.sv
package rxq_steer_pkg;

  localparam int RXQ_CPU_W = 5;

  typedef struct packed {
    logic                 q;
    logic [RXQ_CPU_W-1:0] cpu;
  } rdt_entry_t;

  localparam int RXQ_ENT_W = $bits(rdt_entry_t);

  // classification needs checksum offload off and a nonzero mode
  function automatic logic mq_enabled(input logic csum_off, input logic [1:0] mode);
    return csum_off & (|mode);
  endfunction

endpackage

// File: rtl/rxq_steer_gate.sv
module rxq_steer_gate
  import rxq_steer_pkg::*;
(
  input  logic       cfg_csum_off,
  input  logic [1:0] cfg_mq_mode,
  input  logic       in_valid,
  input  logic       in_decodable,
  output logic       act_o,
  output logic       steer_o
);

  assign act_o   = mq_enabled(cfg_csum_off, cfg_mq_mode);
  assign steer_o = in_valid & act_o & in_decodable;

endmodule

// File: rtl/rxq_steer_table.sv
module rxq_steer_table
  import rxq_steer_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  rdt_entry_t       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output rdt_entry_t       rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  rdt_entry_t slot_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic       hit_w;
    rdt_entry_t q_r;
    assign hit_w = wr_en && (wr_addr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_r <= '0;
      else if (hit_w) q_r <= wr_data;
    end
    assign slot_w[g] = q_r;
  end

  assign rd_data = slot_w[rd_idx];

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_w[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/rxq_steer_outreg.sv
module rxq_steer_outreg
  import rxq_steer_pkg::*;
#(
  parameter int HASH_W = 32,
  parameter int TYPE_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 steer,
  input  logic [HASH_W-1:0]    hash,
  input  logic [TYPE_W-1:0]    htype,
  input  rdt_entry_t           entry,
  output logic                 out_valid,
  output logic                 out_queue,
  output logic [RXQ_CPU_W-1:0] out_cpu,
  output logic [HASH_W-1:0]    out_tag,
  output logic [TYPE_W-1:0]    out_htype
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_queue <= 1'b0;
      out_cpu   <= '0;
      out_tag   <= '0;
      out_htype <= '0;
    end else begin
      out_valid <= in_valid;
      if (steer) begin
        out_queue <= entry.q;
        out_cpu   <= entry.cpu;
        out_tag   <= hash;
        out_htype <= htype;
      end else begin
        out_queue <= 1'b0;
        out_cpu   <= '0;
        out_tag   <= '0;
        out_htype <= '0;
      end
    end
  end

endmodule

// File: rtl/rxq_steer.sv
module rxq_steer
  import rxq_steer_pkg::*;
#(
  parameter int HASH_W = 32,
  parameter int IDX_W  = 7,
  parameter int TYPE_W = 4,
  localparam int STAT_W = TYPE_W + 1 + RXQ_CPU_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_csum_off,
  input  logic [1:0]           cfg_mq_mode,
  input  logic                 tbl_wr_en,
  input  logic [IDX_W-1:0]     tbl_wr_addr,
  input  logic [RXQ_ENT_W-1:0] tbl_wr_data,
  input  logic                 in_valid,
  input  logic [HASH_W-1:0]    in_hash,
  input  logic [TYPE_W-1:0]    in_htype,
  input  logic                 in_decodable,
  output logic                 out_valid,
  output logic                 out_queue,
  output logic [RXQ_CPU_W-1:0] out_cpu,
  output logic [HASH_W-1:0]    out_tag,
  output logic [TYPE_W-1:0]    out_htype,
  output logic [STAT_W-1:0]    out_status
);

  logic       act_w;
  logic       steer_w;
  rdt_entry_t entry_w;

  rxq_steer_gate u_gate (
    .cfg_csum_off (cfg_csum_off),
    .cfg_mq_mode  (cfg_mq_mode),
    .in_valid     (in_valid),
    .in_decodable (in_decodable),
    .act_o        (act_w),
    .steer_o      (steer_w)
  );

  rxq_steer_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_en),
    .wr_addr (tbl_wr_addr),
    .wr_data (rdt_entry_t'(tbl_wr_data)),
    .rd_idx  (in_hash[IDX_W-1:0]),
    .rd_data (entry_w)
  );

  rxq_steer_outreg #(.HASH_W(HASH_W), .TYPE_W(TYPE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .steer     (steer_w),
    .hash      (in_hash),
    .htype     (in_htype),
    .entry     (entry_w),
    .out_valid (out_valid),
    .out_queue (out_queue),
    .out_cpu   (out_cpu),
    .out_tag   (out_tag),
    .out_htype (out_htype)
  );

  assign out_status = {out_htype, out_queue, out_cpu};

  assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_inactive_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !act_w) |=>
      (out_queue == 1'b0 && out_tag == '0 && out_cpu == '0 && out_htype == '0));

  assert_undecodable_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && act_w && !in_decodable) |=>
      (out_queue == 1'b0 && out_tag == '0 && out_cpu == '0 && out_htype == '0));

  assert_tag_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    steer_w |=> out_tag == $past(in_hash));

  assert_type_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    steer_w |=> out_htype == $past(in_htype));

  assert_quiet_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_queue == 1'b0 && out_tag == '0 && out_cpu == '0 && out_htype == '0));

endmodule

// File: tb/rxq_steer_tb_top.sv
module rxq_steer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_csum_off = 1'b0;
  logic [1:0]  cfg_mq_mode = 2'b00;
  logic        tbl_wr_en = 1'b0;
  logic [6:0]  tbl_wr_addr = '0;
  logic [5:0]  tbl_wr_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_hash = '0;
  logic [3:0]  in_htype = '0;
  logic        in_decodable = 1'b0;
  logic        out_valid;
  logic        out_queue;
  logic [4:0]  out_cpu;
  logic [31:0] out_tag;
  logic [3:0]  out_htype;
  logic [9:0]  out_status;

  always #2.5 clk = ~clk;

  rxq_steer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_csum_off(cfg_csum_off), .cfg_mq_mode(cfg_mq_mode),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .in_valid(in_valid), .in_hash(in_hash), .in_htype(in_htype), .in_decodable(in_decodable),
    .out_valid(out_valid), .out_queue(out_queue), .out_cpu(out_cpu), .out_tag(out_tag),
    .out_htype(out_htype), .out_status(out_status)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  int unsigned ref_tbl [128];
  bit          e_valid = 0;
  bit          e_queue = 0;
  int unsigned e_cpu = 0;
  int unsigned e_tag = 0;
  int unsigned e_htype = 0;
  string       e_cat = "R10";
  string       e_phase = "reset";

  task automatic chk(input string req, input string ph, input string field,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, ph, field, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk("R7", e_phase, "out_valid", 64'(out_valid), 64'(e_valid));
    chk(e_cat == "R4" ? "R4" : e_cat, e_phase, "out_queue", 64'(out_queue), 64'(e_queue));
    chk(e_cat == "R4" ? "R4" : e_cat, e_phase, "out_cpu", 64'(out_cpu), 64'(e_cpu));
    chk(e_cat == "R4" ? "R5" : e_cat, e_phase, "out_tag", 64'(out_tag), 64'(e_tag));
    chk(e_cat == "R4" ? "R6" : e_cat, e_phase, "out_htype", 64'(out_htype), 64'(e_htype));
    chk("R11", e_phase, "out_status", 64'(out_status),
        64'((e_htype << 6) + (int'(e_queue) << 5) + e_cpu));
  endtask

  task automatic step(input bit v, input int unsigned h, input int unsigned t, input bit d,
                      input bit cs, input int unsigned m, input bit we,
                      input int unsigned wa, input int unsigned wd, input string ph);
    bit on;
    int unsigned ent;
    @(negedge clk);
    compare_outputs();
    in_valid = v; in_hash = h; in_htype = 4'(t); in_decodable = d;
    cfg_csum_off = cs; cfg_mq_mode = 2'(m);
    tbl_wr_en = we; tbl_wr_addr = 7'(wa); tbl_wr_data = 6'(wd);
    on = (cs == 1'b1) && (m % 4 != 0);
    e_valid = v;
    e_phase = ph;
    if (!v) e_cat = "R10";
    else if (!on) e_cat = "R2";
    else if (!d) e_cat = "R3";
    else e_cat = "R4";
    if (e_cat == "R4") begin
      ent = ref_tbl[h % 128];
      e_queue = ent >= 32;
      e_cpu = ent % 32;
      e_tag = h;
      e_htype = t % 16;
    end else begin
      e_queue = 0; e_cpu = 0; e_tag = 0; e_htype = 0;
    end
    if (we) ref_tbl[wa % 128] = wd % 64;
  endtask

  initial begin
    foreach (ref_tbl[i]) ref_tbl[i] = 0;
    // reset state: R10 all outputs quiet
    repeat (3) begin
      @(negedge clk);
      chk("R10", "reset", "out_valid", 64'(out_valid), 0);
      chk("R10", "reset", "out_status", 64'(out_status), 0);
      chk("R10", "reset", "out_tag", 64'(out_tag), 0);
    end
    rst_n = 1'b1;
    // R8: entries read as zero after reset
    for (int i = 0; i < 16; i++)
      step(1, $urandom, $urandom, 1, 1, 1 + i % 3, 0, 0, 0, "R8_reset_table");
    // R2: fill the whole table while classification is off
    for (int i = 0; i < 128; i++)
      step(1, $urandom, $urandom, 1, i % 2, (i % 2) ? 0 : 3, 1, i, $urandom, "R2_disabled_fill");
    // R1: sweep all enable combinations
    for (int cs = 0; cs < 2; cs++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 6; k++)
          step(1, $urandom, $urandom, 1, cs[0], m, 0, 0, 0, "R1_enable_sweep");
    // R3: undecodable while active
    for (int i = 0; i < 20; i++)
      step(1, $urandom, $urandom, 0, 1, 1 + i % 3, 0, 0, 0, "R3_undecodable");
    // R9: write and lookup on the same entry in one cycle
    for (int i = 0; i < 24; i++) begin
      int unsigned h = $urandom;
      int unsigned nd = (ref_tbl[h % 128] + 1 + ($urandom % 62)) % 64;
      step(1, h, $urandom, 1, 1, 2, 1, h % 128, nd, "R9_same_entry");
      step(1, h, $urandom, 1, 1, 2, 0, 0, 0, "R9_after_write");
    end
    // mixed traffic with gaps, writes and enable changes
    for (int i = 0; i < 2000; i++)
      step(($urandom % 4) != 0, $urandom, $urandom, ($urandom % 5) != 0,
           ($urandom % 6) != 0, $urandom % 4, ($urandom % 3) == 0,
           $urandom % 128, $urandom, "R4_mixed");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "drain");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "drain");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule